// File: doc/BRIEF.md
# Variable-Length Instruction Field Unpacker

This block accepts one shader instruction of variable length, presented as up to `MAX_WORDS` little-endian 32-bit words on a flat bus together with a one-cycle strobe. The first word is a control word. Its header bits give the instruction length, the length of the following instruction, a prefetch flag, an end-of-program flag and a synchronisation request. Twelve enable bits select which functional units carry a payload in this instruction.

The payloads of the enabled units are packed back to back in the words that follow the control word. They are packed least significant bit first, in ascending order of their enable bits. A payload that runs past a 32-bit boundary continues at bit 0 of the next word. The unpacker finds the bit offset of every enabled payload and copies each one into a fixed-width output port with its own valid flag. It also checks that the declared length matches the length the enabled payloads require.

All results are registered and appear exactly one clock after the strobe. They then hold until the next strobe. A front-end places the unpacked fields on this block's ports, and the unit decoders further down the pipe read them from there.

Top module: `instr_field_unpacker`

## Requirements
- R1: The output length equals control bits 4..0. The next-instruction length equals bits 24..19. Prefetch comes from bit 25, end-of-program from bit 5 and the sync request from bit 6.
- R2: `out_unit_valid[k]` equals control bit 7+k for k = 0..11. The unit order is: varying, texture, uniform/temp fetch, vec4 multiply, scalar multiply, vec4 add, scalar add, combiner, temp write, branch, constant 0, constant 1.
- R3: The payload widths are 34, 62, 41, 43, 30, 44, 31, 30, 41, 73, 64 and 64 bits, in unit order. The first enabled payload starts at bus bit 32, and each later enabled payload starts right after the previous enabled one.
- R4: When a payload crosses a 32-bit word boundary, its upper bits are taken from the low bits of the following word.
- R5: The field port of every disabled unit reads zero.
- R6: `out_len_error` is set when the declared length differs from 1 + ceil(sum of enabled payload widths / 32).
- R7: `out_len_error` is set when any of control bits 31..28 is nonzero.
- R8: `out_len_error` is set when the declared length exceeds `MAX_WORDS`, even when it matches the computed length.
- R9: `out_valid` is high for exactly the cycle after each strobe. All other outputs update only on a strobe and hold their values otherwise.
- R10: While reset is asserted, every output reads zero, and reset acts without a clock. Release of reset is synchronised to the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, releases synchronously |
| instr_valid | input | 1 | Strobe: the bus holds an instruction |
| instr_words | input | MAX_WORDS*32 | Instruction words; word 0 (the control word) in bits 31..0 |
| out_valid | output | 1 | High for one cycle when new results are present |
| out_len | output | 5 | Declared instruction length in words |
| out_next_len | output | 6 | Declared length of the next instruction |
| out_prefetch | output | 1 | Prefetch flag |
| out_end_prog | output | 1 | End-of-program flag |
| out_sync_req | output | 1 | Synchronisation request |
| out_len_error | output | 1 | Length or reserved-bit inconsistency |
| out_unit_valid | output | 12 | Per-unit payload valid flags |
| fld_varying | output | 34 | Varying fetch payload |
| fld_texture | output | 62 | Texture payload |
| fld_uniform | output | 41 | Uniform/temporary fetch payload |
| fld_vec_mul | output | 43 | Vec4 multiply payload |
| fld_scl_mul | output | 30 | Scalar multiply payload |
| fld_vec_add | output | 44 | Vec4 add payload |
| fld_scl_add | output | 31 | Scalar add payload |
| fld_combiner | output | 30 | Combiner payload |
| fld_temp_wr | output | 41 | Temporary write payload |
| fld_branch | output | 73 | Branch payload |
| fld_const0 | output | 64 | Constant 0 payload |
| fld_const1 | output | 64 | Constant 1 payload |

## Verification
The bench builds the block with the default `MAX_WORDS` of 18, which gives a 576-bit bus. At that size an instruction with all twelve units enabled needs 19 words. That one case exercises the over-length error while the declared and computed lengths agree, and it also shows the last payload running off the end of the bus. Shorter mixes put each wide payload, including the 73-bit branch field, across one or two word boundaries at different bit phases.

// File: rtl/fu_pkg.sv
package fu_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_UNITS = 12;
  localparam int EN_LSB    = 7;
  localparam int LEN_W     = 5;
  localparam int NXT_W     = 6;
  localparam int SUM_W     = 10;

  // Payload width of each unit, indexed in enable-bit order.
  function automatic int unit_width(input int k);
    case (k)
      0:  return 34;
      1:  return 62;
      2:  return 41;
      3:  return 43;
      4:  return 30;
      5:  return 44;
      6:  return 31;
      7:  return 30;
      8:  return 41;
      9:  return 73;
      10: return 64;
      11: return 64;
      default: return 0;
    endcase
  endfunction

  // Base of unit k inside the flat, densely packed output vector.
  function automatic int flat_base(input int k);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += unit_width(j);
    return acc;
  endfunction

  localparam int FLAT_W = flat_base(NUM_UNITS);

  typedef struct packed {
    logic [3:0]           rsvd;
    logic [1:0]           spare;
    logic                 prefetch;
    logic [NXT_W-1:0]     next_len;
    logic [NUM_UNITS-1:0] unit_en;
    logic                 sync_req;
    logic                 end_prog;
    logic [LEN_W-1:0]     len;
  } ctrl_t;
endpackage

// File: rtl/fu_rst_sync.sv
module fu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/fu_hdr_check.sv
module fu_hdr_check
  import fu_pkg::*;
#(
  parameter int MAX_WORDS = 18
) (
  input  logic [WORD_W-1:0] ctrl_word,
  input  logic [LEN_W-1:0]  calc_len,
  output ctrl_t             hdr,
  output logic              len_error
);
  logic mismatch;
  logic rsvd_set;
  logic over_len;
  logic unused_spare;

  assign hdr          = ctrl_t'(ctrl_word);
  assign unused_spare = ^hdr.spare;

  always_comb begin
    mismatch  = (hdr.len != calc_len);
    rsvd_set  = (hdr.rsvd != 4'b0000);
    over_len  = (int'(hdr.len) > MAX_WORDS);
    len_error = mismatch | rsvd_set | over_len;
  end
endmodule

// File: rtl/fu_offset_calc.sv
module fu_offset_calc
  import fu_pkg::*;
(
  input  logic [NUM_UNITS-1:0]            unit_en,
  output logic [NUM_UNITS-1:0][SUM_W-1:0] offs,
  output logic [LEN_W-1:0]                calc_len
);
  logic [NUM_UNITS:0][SUM_W-1:0] run;
  logic [SUM_W-1:0]              rounded;

  assign run[0] = SUM_W'(WORD_W);

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_acc
    localparam int FW = unit_width(k);
    assign offs[k]  = run[k];
    assign run[k+1] = run[k] + (unit_en[k] ? SUM_W'(FW) : '0);
  end

  assign rounded  = run[NUM_UNITS] + SUM_W'(WORD_W - 1);
  assign calc_len = LEN_W'(rounded >> $clog2(WORD_W));
endmodule

// File: rtl/fu_field_extract.sv
module fu_field_extract
  import fu_pkg::*;
#(
  parameter int BUS_W = 576
) (
  input  logic [BUS_W-1:0]                bus,
  input  logic [NUM_UNITS-1:0]            unit_en,
  input  logic [NUM_UNITS-1:0][SUM_W-1:0] offs,
  output logic [FLAT_W-1:0]               flat
);
  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
    localparam int FW   = unit_width(k);
    localparam int BASE = flat_base(k);
    logic [FW-1:0] slice;
    assign slice             = FW'(bus >> offs[k]);
    assign flat[BASE +: FW]  = unit_en[k] ? slice : '0;
  end
endmodule

// File: rtl/instr_field_unpacker.sv
module instr_field_unpacker
  import fu_pkg::*;
#(
  parameter int MAX_WORDS = 18,
  localparam int BUS_W    = MAX_WORDS * WORD_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       instr_valid,
  input  logic [BUS_W-1:0]           instr_words,
  output logic                       out_valid,
  output logic [LEN_W-1:0]           out_len,
  output logic [NXT_W-1:0]           out_next_len,
  output logic                       out_prefetch,
  output logic                       out_end_prog,
  output logic                       out_sync_req,
  output logic                       out_len_error,
  output logic [NUM_UNITS-1:0]       out_unit_valid,
  output logic [unit_width(0)-1:0]   fld_varying,
  output logic [unit_width(1)-1:0]   fld_texture,
  output logic [unit_width(2)-1:0]   fld_uniform,
  output logic [unit_width(3)-1:0]   fld_vec_mul,
  output logic [unit_width(4)-1:0]   fld_scl_mul,
  output logic [unit_width(5)-1:0]   fld_vec_add,
  output logic [unit_width(6)-1:0]   fld_scl_add,
  output logic [unit_width(7)-1:0]   fld_combiner,
  output logic [unit_width(8)-1:0]   fld_temp_wr,
  output logic [unit_width(9)-1:0]   fld_branch,
  output logic [unit_width(10)-1:0]  fld_const0,
  output logic [unit_width(11)-1:0]  fld_const1
);
  logic                            rst_sync_n;
  ctrl_t                           hdr;
  logic                            len_err_c;
  logic [LEN_W-1:0]                calc_len;
  logic [NUM_UNITS-1:0][SUM_W-1:0] offs;
  logic [FLAT_W-1:0]               flat_c;
  logic [FLAT_W-1:0]               flat_q;

  // next-state values
  logic                            valid_d;
  logic                            cap_en;

  fu_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fu_hdr_check #(.MAX_WORDS(MAX_WORDS)) u_hdr (
    .ctrl_word (instr_words[WORD_W-1:0]),
    .calc_len  (calc_len),
    .hdr       (hdr),
    .len_error (len_err_c)
  );

  fu_offset_calc u_offs (
    .unit_en  (hdr.unit_en),
    .offs     (offs),
    .calc_len (calc_len)
  );

  fu_field_extract #(.BUS_W(BUS_W)) u_extract (
    .bus     (instr_words),
    .unit_en (hdr.unit_en),
    .offs    (offs),
    .flat    (flat_c)
  );

  always_comb begin
    valid_d = instr_valid;
    cap_en  = instr_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid      <= 1'b0;
      out_len        <= '0;
      out_next_len   <= '0;
      out_prefetch   <= 1'b0;
      out_end_prog   <= 1'b0;
      out_sync_req   <= 1'b0;
      out_len_error  <= 1'b0;
      out_unit_valid <= '0;
      flat_q         <= '0;
    end else begin
      out_valid <= valid_d;
      if (cap_en) begin
        out_len        <= hdr.len;
        out_next_len   <= hdr.next_len;
        out_prefetch   <= hdr.prefetch;
        out_end_prog   <= hdr.end_prog;
        out_sync_req   <= hdr.sync_req;
        out_len_error  <= len_err_c;
        out_unit_valid <= hdr.unit_en;
        flat_q         <= flat_c;
      end
    end
  end

  assign fld_varying  = flat_q[flat_base(0)  +: unit_width(0)];
  assign fld_texture  = flat_q[flat_base(1)  +: unit_width(1)];
  assign fld_uniform  = flat_q[flat_base(2)  +: unit_width(2)];
  assign fld_vec_mul  = flat_q[flat_base(3)  +: unit_width(3)];
  assign fld_scl_mul  = flat_q[flat_base(4)  +: unit_width(4)];
  assign fld_vec_add  = flat_q[flat_base(5)  +: unit_width(5)];
  assign fld_scl_add  = flat_q[flat_base(6)  +: unit_width(6)];
  assign fld_combiner = flat_q[flat_base(7)  +: unit_width(7)];
  assign fld_temp_wr  = flat_q[flat_base(8)  +: unit_width(8)];
  assign fld_branch   = flat_q[flat_base(9)  +: unit_width(9)];
  assign fld_const0   = flat_q[flat_base(10) +: unit_width(10)];
  assign fld_const1   = flat_q[flat_base(11) +: unit_width(11)];

  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    instr_valid |=> out_valid); // R9
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !instr_valid |=> !out_valid); // R9
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !instr_valid |=> ($stable(out_len) && $stable(out_unit_valid) && $stable(flat_q))); // R9
  AST_RSVD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr_valid && (instr_words[31:28] != 4'b0000)) |=> out_len_error); // R7
  AST_OVERLEN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && (int'(out_len) > MAX_WORDS)) |-> out_len_error); // R8

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_chk
    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (out_valid && !out_unit_valid[k]) |-> (flat_q[flat_base(k) +: unit_width(k)] == '0)); // R5
  end
endmodule

// File: tb/instr_field_unpacker_tb.sv
module instr_field_unpacker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXW       = 18;
  localparam int BUS_W      = MAXW * 32;
  localparam int NV         = 13;

  typedef struct packed {
    logic [31:0] ctrl;
    logic        exp_err;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{32'h02200083, 1'b0},  // varying only, next len 4, prefetch
    '{32'h00000184, 1'b0},  // varying + texture
    '{32'h00001424, 1'b0},  // vec mul + vec add, end of program
    '{32'h00060005, 1'b0},  // both constants
    '{32'h00000041, 1'b0},  // no units, sync request
    '{32'h00010004, 1'b0},  // branch only
    '{32'h0007FF93, 1'b1},  // all units, 19 words > 18
    '{32'h00006804, 1'b0},  // scalar mul + scalar add + combiner
    '{32'h00001403, 1'b1},  // declared 3, needs 4
    '{32'h12200083, 1'b1},  // reserved bit 28
    '{32'h02288264, 1'b0},  // uniform + temp write, end, sync, next 5
    '{32'h0002FF8F, 1'b0},  // all but branch and const1
    '{32'h0000001F, 1'b1}   // no units, declared 31
  };

  logic             clk;
  logic             rst_n;
  logic             instr_valid;
  logic [BUS_W-1:0] instr_words;
  logic             out_valid;
  logic [4:0]       out_len;
  logic [5:0]       out_next_len;
  logic             out_prefetch, out_end_prog, out_sync_req, out_len_error;
  logic [11:0]      out_unit_valid;
  logic [33:0]      fld_varying;
  logic [61:0]      fld_texture;
  logic [40:0]      fld_uniform;
  logic [42:0]      fld_vec_mul;
  logic [29:0]      fld_scl_mul;
  logic [43:0]      fld_vec_add;
  logic [30:0]      fld_scl_add;
  logic [29:0]      fld_combiner;
  logic [40:0]      fld_temp_wr;
  logic [72:0]      fld_branch;
  logic [63:0]      fld_const0;
  logic [63:0]      fld_const1;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  instr_field_unpacker #(.MAX_WORDS(MAXW)) u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_words(instr_words),
    .out_valid(out_valid), .out_len(out_len), .out_next_len(out_next_len),
    .out_prefetch(out_prefetch), .out_end_prog(out_end_prog), .out_sync_req(out_sync_req),
    .out_len_error(out_len_error), .out_unit_valid(out_unit_valid),
    .fld_varying(fld_varying), .fld_texture(fld_texture), .fld_uniform(fld_uniform),
    .fld_vec_mul(fld_vec_mul), .fld_scl_mul(fld_scl_mul), .fld_vec_add(fld_vec_add),
    .fld_scl_add(fld_scl_add), .fld_combiner(fld_combiner), .fld_temp_wr(fld_temp_wr),
    .fld_branch(fld_branch), .fld_const0(fld_const0), .fld_const1(fld_const1)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int bw(input int k);
    case (k)
      0: return 34;  1: return 62;  2: return 41;  3: return 43;
      4: return 30;  5: return 44;  6: return 31;  7: return 30;
      8: return 41;  9: return 73;  10: return 64; 11: return 64;
      default: return 0;
    endcase
  endfunction

  function automatic logic [72:0] pat(input int n, input int k);
    logic [31:0] a, b, c;
    a = 32'h9E3779B9 * 32'(n*16 + k + 1);
    b = a ^ 32'h5BD1E995 ^ 32'(k*7919);
    c = ~a + 32'(n);
    return {c[8:0], b, a};
  endfunction

  function automatic logic [72:0] wmask(input int w);
    return (73'd1 << w) - 73'd1;
  endfunction

  function automatic logic [72:0] dut_fld(input int k);
    case (k)
      0: return 73'(fld_varying);   1: return 73'(fld_texture);
      2: return 73'(fld_uniform);   3: return 73'(fld_vec_mul);
      4: return 73'(fld_scl_mul);   5: return 73'(fld_vec_add);
      6: return 73'(fld_scl_add);   7: return 73'(fld_combiner);
      8: return 73'(fld_temp_wr);   9: return fld_branch;
      10: return 73'(fld_const0);   11: return 73'(fld_const1);
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string what, input logic [72:0] act, input logic [72:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Packs the payloads of enabled units behind the control word.
  task automatic build(input int n, input logic [31:0] ctrl, output logic [BUS_W-1:0] bus);
    int pos;
    logic [72:0] p;
    bus = '0;
    bus[31:0] = ctrl;
    pos = 32;
    for (int k = 0; k < 12; k++) begin
      if (ctrl[7+k]) begin
        p = pat(n, k);
        for (int b = 0; b < bw(k); b++)
          if (pos + b < BUS_W) bus[pos+b] = p[b];
        pos += bw(k);
      end
    end
  endtask

  task automatic check_out(input int n, input logic [31:0] ctrl, input logic exp_err);
    int pos;
    int w;
    string tag;
    pos = 32;
    chk("R9 out_valid", 73'(out_valid), 73'd1);
    chk("R1 length", 73'(out_len), 73'(ctrl[4:0]));
    chk("R1 end of program", 73'(out_end_prog), 73'(ctrl[5]));
    chk("R1 sync request", 73'(out_sync_req), 73'(ctrl[6]));
    chk("R1 next length", 73'(out_next_len), 73'(ctrl[24:19]));
    chk("R1 prefetch", 73'(out_prefetch), 73'(ctrl[25]));
    chk("R2 unit valid", 73'(out_unit_valid), 73'(ctrl[18:7]));
    if (ctrl[31:28] != 4'b0000)  tag = "R7 reserved-bit error";
    else if (ctrl[4:0] > 5'd18)  tag = "R8 over-length error";
    else                         tag = "R6 length error";
    chk(tag, 73'(out_len_error), 73'(exp_err));
    for (int k = 0; k < 12; k++) begin
      w = bw(k);
      if (ctrl[7+k]) begin
        if (pos + w <= BUS_W) begin
          if ((pos % 32) + w > 32) tag = $sformatf("R4 unit %0d field", k);
          else                     tag = $sformatf("R3 unit %0d field", k);
          chk(tag, dut_fld(k), pat(n, k) & wmask(w));
        end
        pos += w;
      end else begin
        chk($sformatf("R5 unit %0d disabled", k), dut_fld(k), 73'd0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [BUS_W-1:0] bus;
    logic [4:0]       hold_len;
    logic [11:0]      hold_uv;
    logic [72:0]      hold_br;

    rst_n       = 1'b0;
    instr_valid = 1'b0;
    instr_words = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state
    chk("R10 reset out_valid", 73'(out_valid), 73'd0);
    chk("R10 reset unit valid", 73'(out_unit_valid), 73'd0);
    chk("R10 reset length", 73'(out_len), 73'd0);
    chk("R10 reset error", 73'(out_len_error), 73'd0);
    chk("R10 reset branch field", fld_branch, 73'd0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      build(v, VECS[v].ctrl, bus);
      instr_words = bus;
      instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0;
      check_out(v, VECS[v].ctrl, VECS[v].exp_err);
    end

    // R9: outputs hold without a strobe
    hold_len = out_len;
    hold_uv  = out_unit_valid;
    hold_br  = dut_fld(10);
    build(40, 32'h00060005, bus);
    instr_words = bus;
    repeat (3) @(negedge clk);
    chk("R9 no strobe out_valid", 73'(out_valid), 73'd0);
    chk("R9 hold length", 73'(out_len), 73'(hold_len));
    chk("R9 hold unit valid", 73'(out_unit_valid), 73'(hold_uv));
    chk("R9 hold const0 field", dut_fld(10), hold_br);

    // R9: back-to-back strobes, one result per cycle
    build(50, VECS[0].ctrl, bus);
    instr_words = bus;
    instr_valid = 1'b1;
    @(negedge clk);
    check_out(50, VECS[0].ctrl, 1'b0);
    build(51, VECS[5].ctrl, bus);
    instr_words = bus;
    @(negedge clk);
    instr_valid = 1'b0;
    check_out(51, VECS[5].ctrl, 1'b0);
    @(negedge clk);
    chk("R9 single-cycle valid", 73'(out_valid), 73'd0);

    // R10: asynchronous reset assertion mid-run
    build(60, VECS[11].ctrl, bus);
    instr_words = bus;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    chk("R10 async out_valid", 73'(out_valid), 73'd0);
    chk("R10 async unit valid", 73'(out_unit_valid), 73'd0);
    chk("R10 async const0 field", dut_fld(10), 73'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 after release length", 73'(out_len), 73'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule